// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single-cycle access requests from an 8-bit processor core into external bus cycles on a narrow multiplexed bus. The address space is 13 bits wide. The upper five address bits go out on their own dedicated lines. The lower eight bits share one bidirectional byte lane with the data. Each access takes five clocks. First an address strobe frames the low address byte so that outside logic can latch it off the lane. Next comes one turnaround clock with the lane released. Then a two-clock data strobe moves the data, and a final clock hands read data and a done pulse back to the core.

The core raises `start_i` for one clock, together with the address, the direction, write data and an opcode-fetch flag. A start is taken when the sequencer is idle or in the last clock of a cycle, so cycles can run back to back at one fifth of the clock rate. The lane is modelled as separate in, out and output-enable signals for an FPGA pad. While the low-power input `lp_i` (wait or stop mode) is high, no strobe, done pulse or lane drive is produced. A pending or interrupted access then restarts at its first phase once the mode ends.

Top module: `muxbus_seq`

## Requirements
- R1: While `rst` is high, and on the clock after it falls, `as_o`, `ds_o`, `li_o`, `rsp_done_o` and `bus_oe_o` are 0 and `wr_n_o` is 1.
- R2: In the first clock after a start is accepted (phase 0), `as_o` is 1 for exactly one clock. In that clock `bus_oe_o` is 1, `bus_o` equals address bits 7:0, `addr_hi_o` equals address bits 12:8 and `ds_o` is 0.
- R3: Phase 1 is a turnaround clock in which `as_o`, `ds_o` and `bus_oe_o` are all 0.
- R4: `ds_o` is 1 in phases 2 and 3 only. `li_o` is 1 in phases 1 to 3 of a cycle started with `fetch_i`=1, which overlaps both data-strobe clocks, and is 0 otherwise.
- R5: `wr_n_o` is 0 in all five phases of a write (`write_i`=1) and 1 for a read. During the data strobe of a write, `bus_oe_o`=1 and `bus_o` equals the write data. During a read, `bus_oe_o` is 0 in phases 1 to 4.
- R6: For a read, `bus_i` is sampled at the clock edge that ends phase 3, where the data strobe falls. It appears on `rsp_rdata_o` in phase 4, and `rsp_done_o` is 1 in phase 4 only. A write leaves `rsp_rdata_o` unchanged.
- R7: A start given in phase 4 is accepted, and the next `as_o` follows in the very next clock, which makes one cycle every five clocks.
- R8: A start given during phases 0 to 3 is ignored. The running cycle completes with its own address, and the sequencer then goes idle.
- R9: While `lp_i` is 1, `as_o`, `ds_o`, `li_o`, `rsp_done_o` and `bus_oe_o` are 0. A start given while idle is held, and its phase 0 appears in the same clock in which `lp_i` returns to 0.
- R10: If `lp_i` rises during a cycle, that cycle is abandoned with no done pulse. It restarts from phase 0 with the same request once `lp_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-clock access request |
| addr_i | input | 13 | Access address |
| write_i | input | 1 | 1 = write, 0 = read |
| fetch_i | input | 1 | Access is an opcode fetch |
| wdata_i | input | 8 | Write data |
| lp_i | input | 1 | Wait/stop mode; suppresses strobes |
| rsp_rdata_o | output | 8 | Read data returned to the core |
| rsp_done_o | output | 1 | One-clock completion pulse |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| wr_n_o | output | 1 | Direction, low for write |
| li_o | output | 1 | Opcode-fetch indicator |
| addr_hi_o | output | 5 | Address bits 12:8 |
| bus_o | output | 8 | Shared lane, outgoing value |
| bus_oe_o | output | 1 | Shared lane drive enable |
| bus_i | input | 8 | Shared lane, incoming value |

## Verification
A phase counter that is off by one shows up within a clock of the strobe moving. It appears as an address strobe that lasts two clocks, a data strobe with no turnaround before it, or a done pulse that does not line up with the data strobe falling. A wrong latched direction shows as the lane driving during a read data strobe, or as `wr_n_o` at the wrong level, in the same clock. Faulty low-power handling shows as a strobe while `lp_i` is high, or as a missing phase 0 in the clock where it drops. The address-strobe spacing is tracked across whole cycles, so a counter that wraps early is caught at the next cycle boundary.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  localparam int unsigned NUM_PH = 5;
  localparam int unsigned PH_W   = $clog2(NUM_PH);

  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_ADDR = phase_t'(0);
  localparam phase_t PH_TURN = phase_t'(1);
  localparam phase_t PH_DS0  = phase_t'(2);
  localparam phase_t PH_DS1  = phase_t'(3);
  localparam phase_t PH_DONE = phase_t'(NUM_PH - 1);
endpackage

// File: rtl/muxbus_phase_ctr.sv
module muxbus_phase_ctr
  import muxbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   lp,
  output logic   busy,
  output phase_t phase,
  output logic   accept
);
  logic slot_free;

  // idle, or the closing phase of a cycle that is really running
  always_comb begin
    slot_free = !busy || (phase == PH_DONE && !lp);
    accept    = start && slot_free;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      phase <= PH_ADDR;
    end else if (accept) begin
      busy  <= 1'b1;
      phase <= PH_ADDR;
    end else if (busy) begin
      if (lp) begin
        phase <= PH_ADDR;
      end else if (phase == PH_DONE) begin
        busy  <= 1'b0;
        phase <= PH_ADDR;
      end else begin
        phase <= phase + phase_t'(1);
      end
    end
  end
endmodule

// File: rtl/muxbus_lane.sv
module muxbus_lane
  import muxbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              fetch,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  phase_t            phase,
  input  logic              lp,
  input  logic [DATA_W-1:0] bus_in,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_q,
  output logic              fetch_q
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              live;
  logic              in_ds;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr;
      wdata_q <= wdata;
      wr_q    <= write;
      fetch_q <= fetch;
    end
  end

  always_comb begin
    live    = busy && !lp;
    in_ds   = (phase == PH_DS0) || (phase == PH_DS1);
    addr_hi = addr_q[ADDR_W-1:DATA_W];
    bus_out = (phase == PH_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;
    bus_oe  = live && ((phase == PH_ADDR) || (in_ds && wr_q));
  end

  // capture at the edge that ends the second data-strobe clock
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (live && phase == PH_DS1 && !wr_q) begin
      rdata <= bus_in;
    end
  end
endmodule

// File: rtl/muxbus_strobes.sv
module muxbus_strobes
  import muxbus_pkg::*;
(
  input  logic   busy,
  input  phase_t phase,
  input  logic   lp,
  input  logic   wr_q,
  input  logic   fetch_q,
  output logic   as,
  output logic   ds,
  output logic   li,
  output logic   done,
  output logic   wr_n
);
  logic live;

  always_comb begin
    live = busy && !lp;
    as   = live && (phase == PH_ADDR);
    ds   = live && (phase == PH_DS0 || phase == PH_DS1);
    li   = live && fetch_q &&
           (phase == PH_TURN || phase == PH_DS0 || phase == PH_DS1);
    done = live && (phase == PH_DONE);
    wr_n = !(busy && wr_q);
  end
endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lp_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_done_o,
  output logic              as_o,
  output logic              ds_o,
  output logic              wr_n_o,
  output logic              li_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] bus_i
);
  logic   busy;
  phase_t phase;
  logic   accept;
  logic   wr_q;
  logic   fetch_q;

  muxbus_phase_ctr u_ctr (
    .clk    (clk),
    .rst    (rst),
    .start  (start_i),
    .lp     (lp_i),
    .busy   (busy),
    .phase  (phase),
    .accept (accept)
  );

  muxbus_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .addr    (addr_i),
    .write   (write_i),
    .fetch   (fetch_i),
    .wdata   (wdata_i),
    .busy    (busy),
    .phase   (phase),
    .lp      (lp_i),
    .bus_in  (bus_i),
    .addr_hi (addr_hi_o),
    .bus_out (bus_o),
    .bus_oe  (bus_oe_o),
    .rdata   (rsp_rdata_o),
    .wr_q    (wr_q),
    .fetch_q (fetch_q)
  );

  muxbus_strobes u_strb (
    .busy    (busy),
    .phase   (phase),
    .lp      (lp_i),
    .wr_q    (wr_q),
    .fetch_q (fetch_q),
    .as      (as_o),
    .ds      (ds_o),
    .li      (li_o),
    .done    (rsp_done_o),
    .wr_n    (wr_n_o)
  );
endmodule

// File: rtl/muxbus_seq_chk.sv
module muxbus_seq_chk
  import muxbus_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic lp_i,
  input logic as_o,
  input logic ds_o,
  input logic wr_n_o,
  input logic li_o,
  input logic rsp_done_o,
  input logic bus_oe_o
);
  logic [3:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst || lp_i) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (as_o) begin
      seen <= 1'b1;
      gap  <= '0;
    end else if (gap != 4'hF) begin
      gap <= gap + 4'd1;
    end
  end

  // R2
  as_drives_lane_chk: assert property (@(posedge clk) disable iff (rst)
    as_o |-> (bus_oe_o && !ds_o));

  // R2
  as_single_chk: assert property (@(posedge clk) disable iff (rst)
    as_o |=> !as_o);

  // R3
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ds_o) |-> $past(!as_o && !ds_o));

  // R4
  li_no_as_chk: assert property (@(posedge clk) disable iff (rst)
    li_o |-> !as_o);

  // R5
  write_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_o && bus_oe_o) |-> !wr_n_o);

  // R5
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_o && wr_n_o) |-> !bus_oe_o);

  // R6
  done_at_ds_fall_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done_o |-> $fell(ds_o));

  // R7
  as_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (as_o && seen) |-> (gap >= 4'(NUM_PH - 1)));

  // R9
  lp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lp_i |-> (!as_o && !ds_o && !li_o && !rsp_done_o && !bus_oe_o));
endmodule

bind muxbus_seq muxbus_seq_chk chk_i (.*);

// File: tb/muxbus_seq_tb_top.sv
module muxbus_seq_tb_top;
  typedef struct packed {
    logic [12:0] addr;
    logic        wr;
    logic        fe;
    logic [7:0]  wd;
    logic [7:0]  rv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{13'h1A5C, 1'b0, 1'b1, 8'h00, 8'h3C},
    '{13'h0001, 1'b1, 1'b0, 8'hA5, 8'h00},
    '{13'h1FFF, 1'b0, 1'b0, 8'h00, 8'hFF},
    '{13'h0F00, 1'b1, 1'b0, 8'h00, 8'h77},
    '{13'h10FE, 1'b0, 1'b1, 8'h00, 8'h81},
    '{13'h0B2D, 1'b1, 1'b0, 8'h5A, 8'h12}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic        write_i = 1'b0;
  logic        fetch_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        lp_i = 1'b0;
  logic [7:0]  bus_i = '0;
  logic [7:0]  rsp_rdata_o;
  logic        rsp_done_o, as_o, ds_o, wr_n_o, li_o, bus_oe_o;
  logic [4:0]  addr_hi_o;
  logic [7:0]  bus_o;

  int nchk = 0;
  int nbad = 0;
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;

  muxbus_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .write_i(write_i), .fetch_i(fetch_i), .wdata_i(wdata_i), .lp_i(lp_i),
    .rsp_rdata_o(rsp_rdata_o), .rsp_done_o(rsp_done_o), .as_o(as_o),
    .ds_o(ds_o), .wr_n_o(wr_n_o), .li_o(li_o), .addr_hi_o(addr_hi_o),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .bus_i(bus_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // all strobes quiet and the lane released
  task automatic chk_idle(input string req);
    chk(req, {27'd0, as_o, ds_o, li_o, rsp_done_o, bus_oe_o}, 32'd0);
    chk(req, {31'd0, wr_n_o}, 32'd1);
  endtask

  // call at a negedge; the next posedge accepts
  task automatic issue(input vec_t v);
    start_i = 1'b1;
    addr_i  = v.addr;
    write_i = v.wr;
    fetch_i = v.fe;
    wdata_i = v.wd;
    bus_i   = v.rv;
  endtask

  // walk phases 0..4; returns 1 time unit after the phase-4 negedge
  task automatic observe(input vec_t v);
    @(negedge clk); start_i = 1'b0; #1;
    // R2 address phase
    chk("R2 as", {31'd0, as_o}, 32'd1);
    chk("R2 lane", {23'd0, bus_oe_o, bus_o}, {23'd0, 1'b1, v.addr[7:0]});
    chk("R2 hi", {27'd0, addr_hi_o}, {27'd0, v.addr[12:8]});
    chk("R5 wr_n ph0", {31'd0, wr_n_o}, {31'd0, ~v.wr});
    @(negedge clk); #1;
    // R3 turnaround
    chk("R3 turn", {29'd0, as_o, ds_o, bus_oe_o}, 32'd0);
    chk("R4 li ph1", {31'd0, li_o}, {31'd0, v.fe});
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      chk("R4 ds", {30'd0, as_o, ds_o}, 32'd1);
      chk("R4 li", {31'd0, li_o}, {31'd0, v.fe});
      chk("R5 wr_n", {31'd0, wr_n_o}, {31'd0, ~v.wr});
      if (v.wr) chk("R5 wdata", {23'd0, bus_oe_o, bus_o}, {23'd0, 1'b1, v.wd});
      else      chk("R5 release", {31'd0, bus_oe_o}, 32'd0);
    end
    @(negedge clk); #1;
    if (!v.wr) last_rd = v.rv;
    chk("R6 done", {29'd0, rsp_done_o, ds_o, li_o}, 32'd4);
    chk("R6 rdata", {24'd0, rsp_rdata_o}, {24'd0, last_rd});
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    #1 chk_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk); #1 chk_idle("R1 after reset");

    // table walk, one idle clock between cycles
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); issue(VECS[i]);
      observe(VECS[i]);
      @(negedge clk); #1 chk_idle("R8 idle after cycle");
    end

    // R7 back to back: start during phase 4
    @(negedge clk); issue(VECS[2]);
    observe(VECS[2]);
    issue(VECS[1]);
    observe(VECS[1]);
    @(negedge clk); #1 chk_idle("R7 idle after pair");

    // R8 start mid-cycle is ignored
    @(negedge clk); issue(VECS[0]);
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); issue(VECS[3]);
    @(negedge clk); start_i = 1'b0; #1;
    chk("R8 ds runs", {31'd0, ds_o}, 32'd1);
    chk("R8 still read", {31'd0, wr_n_o}, 32'd1);
    @(negedge clk);
    @(negedge clk); #1 chk("R8 done", {31'd0, rsp_done_o}, 32'd1);
    @(negedge clk); #1 chk_idle("R8 no extra cycle");
    chk("R8 hi kept", {27'd0, addr_hi_o}, {27'd0, VECS[0].addr[12:8]});

    // R9 start while in low-power mode is held
    @(negedge clk); lp_i = 1'b1; issue(VECS[4]);
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R9 quiet", {27'd0, as_o, ds_o, li_o, rsp_done_o, bus_oe_o}, 32'd0);
    end
    @(negedge clk); lp_i = 1'b0; #1;
    chk("R9 resume ph0", {30'd0, as_o, bus_oe_o}, 32'd3);
    chk("R9 resume addr", {24'd0, bus_o}, {24'd0, VECS[4].addr[7:0]});
    for (int k = 0; k < 4; k++) @(negedge clk);
    #1 chk("R9 done", {31'd0, rsp_done_o}, 32'd1);

    // R10 low-power entry mid-cycle aborts and replays
    v = VECS[5];
    @(negedge clk); issue(v);
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    @(negedge clk); lp_i = 1'b1; #1;
    chk("R10 ds gated", {29'd0, ds_o, bus_oe_o, rsp_done_o}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R10 no done", {31'd0, rsp_done_o}, 32'd0);
    end
    lp_i = 1'b0; #1;
    chk("R10 replay ph0", {31'd0, as_o}, 32'd1);
    chk("R10 replay addr", {24'd0, bus_o}, {24'd0, v.addr[7:0]});
    @(negedge clk); #1 chk("R10 turn", {30'd0, as_o, ds_o}, 32'd0);
    @(negedge clk); #1 chk("R10 wdata", {23'd0, bus_oe_o, bus_o}, {23'd0, 1'b1, v.wd});
    @(negedge clk);
    @(negedge clk); #1 chk("R10 done", {31'd0, rsp_done_o}, 32'd1);

    // R1 reset in the middle of a cycle
    @(negedge clk); issue(VECS[1]);
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #1 chk_idle("R1 reset mid-cycle");
    rst = 1'b0;
    @(negedge clk); #1 chk_idle("R1 after mid reset");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule